// File: doc/BRIEF.md
# Gated Synchronizable Clock Generator

This block derives a square wave from a fast reference clock. The output period is two half periods, and the half period is a build-time count of reference cycles. An active-low run input gates the generator. Each falling edge of the run input restarts the waveform from phase zero, so the output can be lined up with an external event. Each rising edge stops it.

There are two outputs. The lead output starts high as soon as the start is recognised. The lag output carries the same waveform one half period later, so both outputs change on the same reference edges. When the block stops, the lead output's level at that moment decides how the last pulses end. A low lead output stays low, and the lag output finishes a full half-period pulse. A high lead output is cut short at once, and the lag output then repeats that shortened pulse, narrower than a half period, before both go quiet.

The run input may change at any time. It passes through a two-stage synchronizer and then an edge detector, so the outputs react on the third reference edge after the input changes.

Top module: `gated_clkgen`

## Requirements
- R1: While syncRst is high, leadOut and lagOut are low after the first reference edge, whatever the level of runN.
- R2: After runN falls, leadOut rises on the third rising refClk edge, is low for the two edges before that, and then stays high for exactly HALF_PERIOD cycles. lagOut is low at that third edge.
- R3: While running, leadOut toggles every HALF_PERIOD cycles. Its period is 2*HALF_PERIOD and it is high in the first half of each period, counted from the start edge.
- R4: lagOut stays low for the first HALF_PERIOD cycles after the start. From then on it equals leadOut delayed by HALF_PERIOD cycles. While running, that makes it the complement of leadOut, changing on the same edges.
- R5: A stop is seen on the third rising edge after runN rises. If leadOut is low at that edge, leadOut stays low. lagOut stays high until its current half-period pulse has lasted exactly HALF_PERIOD cycles, and then both outputs stay low.
- R6: If leadOut is high at the stop edge and its half period is not in its last cycle, leadOut goes low at that edge. After the half period ends, lagOut gives one pulse as wide as the cut leadOut pulse (c+1 cycles, where c cycles of that half period had passed), which is narrower than HALF_PERIOD. Then both outputs stay low.
- R7: A stop edge that falls in the last cycle of a high leadOut half period lets that half period end normally. lagOut then gives one full HALF_PERIOD pulse, and both outputs stay low.
- R8: While stopped with runN high, both outputs stay low.
- R9: A falling edge of runN that is seen while a final pulse is still pending abandons that pulse. The waveform restarts from phase zero exactly as in R2 to R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference clock; all state changes on its rising edge |
| syncRst | input | 1 | Synchronous reset, active high |
| runN | input | 1 | Active-low run request; may be asynchronous to refClk |
| lagOut | output | 1 | Lagging output: the lead waveform delayed by one half period |
| leadOut | output | 1 | Leading output: starts high as soon as a start is recognised |

## Verification
The assertions check the per-cycle rules on every cycle. The half-period counter never passes its last value. A start always leaves the lead output high, the lag output low and the count at zero. The lead output rises only on a start or a normal half-period wrap, and the lag output rises only on a wrap. A cut happens only while the lead output is high, and the lead output is low whenever the controller is idle. The bench scenarios cover the rest, which depends on whole waveforms. These are the three-edge start latency, the exact pulse widths, the half-period offset of the lag output, and the stop behaviour at every phase of the period, which the bench sweeps one cycle at a time. A separate scenario covers a restart during a pending final pulse.

// File: rtl/gated_clkgen_pkg.sv
package gated_clkgen_pkg;

  typedef enum logic [2:0] {
    S_IDLE      = 3'd0,
    S_RUN       = 3'd1,
    S_DRAIN     = 3'd2,
    S_CUT_WAIT  = 3'd3,
    S_TAIL      = 3'd4
  } oscState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic start;      // restart phase: count zero, lead high, lag low
    logic clear;      // force both outputs low, count zero
    logic advance;    // step the half-period counter
    logic runWrap;    // on a wrap: toggle lead, lag takes old lead
    logic cut;        // drop lead now, remember elapsed count
    logic tailBegin;  // raise lag for the shortened final pulse
  } oscStrobes_t;

  // Status from datapath to control
  typedef struct packed {
    logic wrap;       // counter sits on its last value
    logic tailEnd;    // shortened pulse has reached its length
    logic leadHigh;   // current lead output level
  } oscStatus_t;

endpackage

// File: rtl/gated_clkgen_sync.sv
module gated_clkgen_sync #(
  parameter int STAGES = 2
) (
  input  logic refClk,
  input  logic syncRst,
  input  logic runN,
  output logic fallDet,
  output logic riseDet
);

  logic [STAGES-1:0] chain;
  logic              prevLvl;

  // Synchronizer chain, reset to the stopped (high) level
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge refClk) begin
          if (syncRst) chain[i] <= 1'b1;
          else         chain[i] <= runN;
        end
      end else begin : g_next
        always_ff @(posedge refClk) begin
          if (syncRst) chain[i] <= 1'b1;
          else         chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge refClk) begin
    if (syncRst) prevLvl <= 1'b1;
    else         prevLvl <= chain[STAGES-1];
  end

  assign fallDet = prevLvl & ~chain[STAGES-1];
  assign riseDet = ~prevLvl & chain[STAGES-1];

endmodule

// File: rtl/gated_clkgen_ctrl.sv
module gated_clkgen_ctrl
  import gated_clkgen_pkg::*;
(
  input  logic        refClk,
  input  logic        syncRst,
  input  logic        fallDet,
  input  logic        riseDet,
  input  oscStatus_t  stat,
  output oscStrobes_t strobes
);

  oscState_t state, nextState;

  always_comb begin
    strobes   = '0;
    nextState = state;
    if (fallDet) begin
      strobes.start = 1'b1;
      nextState     = S_RUN;
    end else begin
      unique case (state)
        S_IDLE: ;
        S_RUN: begin
          strobes.advance = 1'b1;
          if (!riseDet) begin
            strobes.runWrap = 1'b1;
          end else if (!stat.leadHigh) begin
            if (stat.wrap) begin
              strobes.clear = 1'b1;
              nextState     = S_IDLE;
            end else begin
              nextState = S_DRAIN;
            end
          end else if (stat.wrap) begin
            strobes.runWrap = 1'b1;
            nextState       = S_DRAIN;
          end else begin
            strobes.cut = 1'b1;
            nextState   = S_CUT_WAIT;
          end
        end
        S_DRAIN: begin
          strobes.advance = 1'b1;
          if (stat.wrap) begin
            strobes.clear = 1'b1;
            nextState     = S_IDLE;
          end
        end
        S_CUT_WAIT: begin
          strobes.advance = 1'b1;
          if (stat.wrap) begin
            strobes.tailBegin = 1'b1;
            nextState         = S_TAIL;
          end
        end
        S_TAIL: begin
          strobes.advance = 1'b1;
          if (stat.tailEnd) begin
            strobes.clear = 1'b1;
            nextState     = S_IDLE;
          end
        end
        default: nextState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge refClk) begin
    if (syncRst) state <= S_IDLE;
    else         state <= nextState;
  end

  // R2: a detected falling edge always lands in the running state
  p_start_runs_r2: assert property (@(posedge refClk) disable iff (syncRst)
    fallDet |=> (state == S_RUN));

  // R8: the datapath never shows a high lead output while idle
  p_idle_lead_low_r8: assert property (@(posedge refClk) disable iff (syncRst)
    (state == S_IDLE) |-> !stat.leadHigh);

  // R9: a restart from any pending-pulse state goes back to running
  p_restart_drain_r9: assert property (@(posedge refClk) disable iff (syncRst)
    (fallDet && (state != S_IDLE)) |=> (state == S_RUN));

endmodule

// File: rtl/gated_clkgen_dp.sv
module gated_clkgen_dp
  import gated_clkgen_pkg::*;
#(
  parameter int HALF_PERIOD = 4
) (
  input  logic        refClk,
  input  logic        syncRst,
  input  oscStrobes_t strobes,
  output oscStatus_t  stat,
  output logic        lagOut,
  output logic        leadOut
);

  localparam int CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_PERIOD - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] truncLast;
  logic             lead, lag;
  logic             wrap;

  assign wrap = (cnt == LAST);

  always_ff @(posedge refClk) begin
    if (syncRst) begin
      cnt       <= '0;
      truncLast <= '0;
      lead      <= 1'b0;
      lag       <= 1'b0;
    end else if (strobes.start) begin
      cnt  <= '0;
      lead <= 1'b1;
      lag  <= 1'b0;
    end else if (strobes.clear) begin
      cnt  <= '0;
      lead <= 1'b0;
      lag  <= 1'b0;
    end else begin
      if (strobes.advance) cnt <= wrap ? '0 : cnt + 1'b1;
      if (strobes.runWrap && wrap) begin
        lead <= ~lead;
        lag  <= lead;
      end
      if (strobes.cut) begin
        lead      <= 1'b0;
        truncLast <= cnt;
      end
      if (strobes.tailBegin) lag <= 1'b1;
    end
  end

  assign stat.wrap     = wrap;
  assign stat.tailEnd  = (cnt == truncLast);
  assign stat.leadHigh = lead;
  assign leadOut       = lead;
  assign lagOut        = lag;

  // R3: the half-period counter never passes its last value
  p_cnt_bound_r3: assert property (@(posedge refClk) disable iff (syncRst)
    cnt <= LAST);

  // R2: a start leaves lead high, lag low and phase at zero
  p_start_levels_r2: assert property (@(posedge refClk) disable iff (syncRst)
    strobes.start |=> (lead && !lag && cnt == '0));

  // R3: lead rises only on a start or on a running wrap
  p_lead_rise_r3: assert property (@(posedge refClk) disable iff (syncRst)
    $rose(lead) |-> ($past(strobes.start) || ($past(strobes.runWrap) && $past(wrap))));

  // R4: lag rises only at the end of a half period
  p_lag_rise_r4: assert property (@(posedge refClk) disable iff (syncRst)
    $rose(lag) |-> $past(wrap));

  // R6: a cut only happens while lead is high and before its last cycle
  p_cut_when_high_r6: assert property (@(posedge refClk) disable iff (syncRst)
    strobes.cut |-> (lead && !wrap));

  // R6: after a cut, lead is low and the kept length is short of a half period
  p_cut_narrow_r6: assert property (@(posedge refClk) disable iff (syncRst)
    strobes.cut |=> (!lead && truncLast < LAST));

endmodule

// File: rtl/gated_clkgen.sv
module gated_clkgen
  import gated_clkgen_pkg::*;
#(
  parameter int HALF_PERIOD = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic refClk,
  input  logic syncRst,
  input  logic runN,
  output logic lagOut,
  output logic leadOut
);

  logic        fallDet, riseDet;
  oscStrobes_t strobes;
  oscStatus_t  stat;

  gated_clkgen_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .refClk  (refClk),
    .syncRst (syncRst),
    .runN    (runN),
    .fallDet (fallDet),
    .riseDet (riseDet)
  );

  gated_clkgen_ctrl ctrl_i (
    .refClk  (refClk),
    .syncRst (syncRst),
    .fallDet (fallDet),
    .riseDet (riseDet),
    .stat    (stat),
    .strobes (strobes)
  );

  gated_clkgen_dp #(.HALF_PERIOD(HALF_PERIOD)) dp_i (
    .refClk  (refClk),
    .syncRst (syncRst),
    .strobes (strobes),
    .stat    (stat),
    .lagOut  (lagOut),
    .leadOut (leadOut)
  );

endmodule

// File: tb/gated_clkgen_tb_top.sv
module gated_clkgen_tb_top;

  localparam int H = 4;

  logic refClk = 1'b0;
  logic syncRst = 1'b1;
  logic runN = 1'b1;
  logic lagOut, leadOut;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #2 refClk = ~refClk;

  gated_clkgen #(.HALF_PERIOD(H), .SYNC_STAGES(2)) dut_i (
    .refClk  (refClk),
    .syncRst (syncRst),
    .runN    (runN),
    .lagOut  (lagOut),
    .leadOut (leadOut)
  );

  task automatic chk(input string req, input string what, input int t,
                     input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s t=%0d actual=%0b expected=%0b", req, what, t, act, exp);
    end
  endtask

  function automatic bit runLead(input int t);
    return ((t / H) % 2) == 0;
  endfunction

  function automatic bit runLag(input int t);
    return (t >= H) && (((t / H) % 2) == 1);
  endfunction

  // Expected levels when the stop is seen on the edge after sample s
  function automatic void expStop(input int t, input int s,
                                  output bit eLag, output bit eLead,
                                  output string req);
    int u, c;
    if (t <= s) begin
      eLead = runLead(t);
      eLag  = runLag(t);
      req   = (t < H) ? "R2" : "R4";
      return;
    end
    u = t - s;
    c = s % H;
    eLead = 1'b0;
    if (!runLead(s)) begin
      eLag = (u <= H - 1 - c);
      req  = "R5";
    end else if (c == H - 1) begin
      eLag = (u <= H);
      req  = "R7";
    end else begin
      eLag = (u >= H - c) && (u <= H);
      req  = "R6";
    end
  endfunction

  // Start at a negedge; sample index t=0 is the third negedge after
  task automatic startSeq();
    runN = 1'b0;
    @(negedge refClk);
    chk("R2", "lead before start", -2, leadOut, 1'b0);
    @(negedge refClk);
    chk("R2", "lead before start", -1, leadOut, 1'b0);
    @(negedge refClk);
  endtask

  task automatic stopSweep(input int d);
    int    s;
    bit    eLag, eLead;
    string req;
    s = d + 2;
    startSeq();
    for (int t = 0; t <= s + 2 * H + 3; t++) begin
      expStop(t, s, eLag, eLead, req);
      chk(req, "lead", t, leadOut, eLead);
      chk(req, "lag", t, lagOut, eLag);
      if (t == d) runN = 1'b1;
      @(negedge refClk);
    end
    repeat (4) @(negedge refClk);
  endtask

  initial begin
    int s;
    repeat (3) @(negedge refClk);
    // R1: reset holds outputs low even with run requested
    runN = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge refClk);
      chk("R1", "lead in reset", i, leadOut, 1'b0);
      chk("R1", "lag in reset", i, lagOut, 1'b0);
    end
    runN = 1'b1;
    repeat (4) @(negedge refClk);
    syncRst = 1'b0;
    // R8: stopped and idle, nothing toggles
    for (int i = 0; i < 12; i++) begin
      @(negedge refClk);
      chk("R8", "lead idle", i, leadOut, 1'b0);
      chk("R8", "lag idle", i, lagOut, 1'b0);
    end
    // R3/R4: long run, then stop at every phase of the period
    startSeq();
    for (int t = 0; t < 8 * H; t++) begin
      chk("R3", "lead run", t, leadOut, runLead(t));
      chk("R4", "lag run", t, lagOut, runLag(t));
      @(negedge refClk);
    end
    runN = 1'b1;
    repeat (4 * H + 6) @(negedge refClk);
    chk("R8", "lead after stop", 0, leadOut, 1'b0);
    chk("R8", "lag after stop", 0, lagOut, 1'b0);
    for (int d = 0; d < 4 * H; d++) stopSweep(d);
    // R9: restart while a cut pulse is pending
    s = 2 * H;
    startSeq();
    for (int t = 0; t <= s + 5 * H; t++) begin
      if (t <= s) begin
        chk("R9", "lead pre", t, leadOut, runLead(t));
        chk("R9", "lag pre", t, lagOut, runLag(t));
      end else if (t == s + 1) begin
        chk("R9", "lead cut", t, leadOut, 1'b0);
        chk("R9", "lag cut", t, lagOut, 1'b0);
      end else begin
        chk("R9", "lead restart", t, leadOut, runLead(t - s - 2));
        chk("R9", "lag restart", t, lagOut, runLag(t - s - 2));
      end
      if (t == s - 2) runN = 1'b1;
      if (t == s - 1) runN = 1'b0;
      @(negedge refClk);
    end
    runN = 1'b1;
    repeat (4 * H + 6) @(negedge refClk);
    chk("R8", "lead final", 0, leadOut, 1'b0);
    chk("R8", "lag final", 0, lagOut, 1'b0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge refClk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule